// File: doc/BRIEF.md
# YCrCb 4:2:2 Pixel Output Formatter

This block takes a luma sample, a chroma sample and a per-pixel valid flag, all on one clock. It places them on a double-width pixel bus: luma in the upper byte and chroma in the lower byte. With the bus it drives a registered valid flag and a flag that marks which chroma component is on the bus. Chroma alternates Cb, Cr, Cb, ... and the order advances only on valid pixels. The block tracks that order itself, so the upstream source supplies the chroma samples in order and no phase marker.

The valid flag passes through unchanged. It does not depend on any horizontal or vertical active-window signal, and the block has no such input. A valid pixel can therefore appear outside the active picture. During an invalid pixel, the data bytes and the Cb flag keep their values from the last valid pixel.

Input samples are captured on the rising edge of the clock. The final output register is loaded on the falling edge. A receiver that samples on the rising edge of the forwarded output clock therefore sees about half a period of setup and half a period of hold.

Top module: `ycc422_formatter`

## Requirements
- R1: While `rst` is high at a rising edge, the output bus, `valid_o` and `cb_o` are all cleared to 0 at the following falling edge. The first valid pixel after reset is therefore marked Cb (`cb_o` = 1).
- R2: For a valid input pixel, `bus_o[2W-1:W]` carries the luma sample and `bus_o[W-1:0]` carries the chroma sample. Both appear at the falling edge after the rising edge that captured them.
- R3: `cb_o` inverts on every valid pixel: 1 (Cb) on the first valid pixel after reset, then 0 (Cr), then 1, and so on.
- R4: For an invalid input pixel, both bytes of `bus_o` keep the values of the last valid pixel, whatever `y_i` and `c_i` carry.
- R5: For an invalid input pixel, `cb_o` keeps the value of the last valid pixel.
- R6: `valid_o` equals the `valid_i` captured at the preceding rising edge, for any data pattern.
- R7: The outputs change only at a falling edge of `clk`. Just after a rising edge they still hold the values launched at the previous falling edge. `pclk_o` is `clk` forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| y_i | input | W | Luma sample |
| c_i | input | W | Chroma sample (Cb and Cr interleaved) |
| valid_i | input | 1 | Pixel valid qualifier |
| pclk_o | output | 1 | Forwarded output clock |
| bus_o | output | 2W | Luma (upper byte) and chroma (lower byte) |
| valid_o | output | 1 | Registered pixel valid qualifier |
| cb_o | output | 1 | High when Cb is on the chroma byte |

## Verification
Every result is due half a cycle after the rising edge that captures its input, at the next falling edge. The bench drives inputs just after a falling edge and checks the outputs one nanosecond after the following falling edge. It also samples one nanosecond after each rising edge to confirm that nothing has moved yet. Sweeps over several valid patterns (all valid, alternating, sparse and bursts) exercise the Cb/Cr alternation and the hold behaviour. A mid-run reset checks that the first valid pixel after it is marked Cb again.

// File: rtl/ycc422_formatter.sv
module ycc422_formatter #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   y_i,
  input  logic [W-1:0]   c_i,
  input  logic           valid_i,
  output logic           pclk_o,
  output logic [2*W-1:0] bus_o,
  output logic           valid_o,
  output logic           cb_o
);
  localparam int BW = 2 * W;

  logic [W-1:0] y_q, c_q;
  logic         v_q, cb_q;

  assign pclk_o = clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      c_q  <= '0;
      v_q  <= 1'b0;
      cb_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        y_q  <= y_i;
        c_q  <= c_i;
        cb_q <= ~cb_q;
      end
    end
  end

  // launch stage: outputs move on the falling edge only
  always_ff @(negedge clk) begin
    bus_o   <= {y_q, c_q};
    valid_o <= v_q;
    cb_o    <= cb_q;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (bus_o == '0 && !valid_o && !cb_o));

  assert_data_map_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(valid_i)) |->
      (bus_o[BW-1:W] == $past(y_i) && bus_o[W-1:0] == $past(c_i)));

  assert_cb_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(valid_i)) |-> (cb_o != $past(cb_o)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!valid_i)) |-> $stable(bus_o));

  assert_cb_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!valid_i)) |-> $stable(cb_o));

  assert_valid_pass_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (valid_o == $past(valid_i)));
endmodule

// File: tb/ycc422_formatter_bench.sv
`timescale 1ns/1ps
module ycc422_formatter_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   y_i = '0, c_i = '0;
  logic           valid_i = 1'b0;
  logic           pclk_o;
  logic [2*W-1:0] bus_o;
  logic           valid_o, cb_o;

  int checks = 0, fails = 0;
  logic [2*W-1:0] e_bus;
  logic           e_v, e_cb;

  ycc422_formatter #(.W(W)) u_ycc422_formatter (
    .clk(clk), .rst(rst), .y_i(y_i), .c_i(c_i), .valid_i(valid_i),
    .pclk_o(pclk_o), .bus_o(bus_o), .valid_o(valid_o), .cb_o(cb_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [W-1:0] y, input logic [W-1:0] c);
    rst = r; valid_i = v; y_i = y; c_i = c;
    @(posedge clk); #1;
    chk("R7 bus stable after rise", bus_o, e_bus);
    chk("R7 valid stable after rise", valid_o, e_v);
    chk("R7 cb stable after rise", cb_o, e_cb);
    chk("R7 pclk forwarded", pclk_o, clk);
    if (r) begin
      e_bus = '0; e_v = 1'b0; e_cb = 1'b0;
    end else begin
      e_v = v;
      if (v) begin
        e_bus = {y, c};
        e_cb  = ~e_cb;
      end
    end
    @(negedge clk); #1;
    if (r) begin
      chk("R1 reset bus", bus_o, 0);
      chk("R1 reset valid", valid_o, 0);
      chk("R1 reset cb", cb_o, 0);
    end else begin
      chk(v ? "R2 data map" : "R4 data hold", bus_o, e_bus);
      chk("R6 valid pass", valid_o, e_v);
      chk(v ? "R3 cb toggle" : "R5 cb hold", cb_o, e_cb);
    end
  endtask

  function automatic logic vpat(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return i[0];
      2: return (i % 3) == 0;
      3: return i[2];
      default: return ((i * 7 + 3) % 5) < 2;
    endcase
  endfunction

  initial begin
    @(negedge clk); #1;
    e_bus = '0; e_v = 1'b0; e_cb = 1'b0;
    step(1'b1, 1'b1, 8'hAA, 8'h55);
    step(1'b1, 1'b0, 8'h00, 8'h00);
    // R1: first valid after reset is Cb
    step(1'b0, 1'b1, 8'h10, 8'h80);
    chk("R1 first valid is Cb", cb_o, 1);
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 64; i++) begin
        step(1'b0, vpat(p, i), W'((i * 37 + p * 11 + 5) & 255), W'((i * 91 + p * 29 + 3) & 255));
      end
    end
    // R4/R5: long invalid run with changing data
    for (int i = 0; i < 256; i++) step(1'b0, 1'b0, W'(i), W'(255 - i));
    // mid-run reset, then R1 again
    step(1'b0, 1'b1, 8'h01, 8'h02);
    step(1'b1, 1'b1, 8'h33, 8'h44);
    step(1'b0, 1'b0, 8'h77, 8'h88);
    step(1'b0, 1'b1, 8'hFF, 8'h00);
    chk("R1 Cb after mid reset", cb_o, 1);
    step(1'b0, 1'b1, 8'h00, 8'hFF);
    chk("R3 Cr second", cb_o, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule